// File: doc/BRIEF.md
# Programmable Periodic Interval Timer

This block produces a periodic interrupt whose interval is set by software through a single reload register. A prescaler divides the system clock down to a one-cycle strobe at a 1 kHz base rate. A period counter counts those base ticks, and a period lasts reload + 1 base ticks, which gives an interrupt rate of 1000 / (reload + 1) Hz. Each time a period ends, a level interrupt is raised. It stays raised until software acknowledges it.

Software reaches the timer through one register location, selected by an address-select input together with a read or a write strobe. A write loads the 9-bit reload value, clears the interrupt and restarts both the prescaler and the period counter from zero. A read returns the current reload value and clears the interrupt. The timing grid is left running during a read.

Top module: `pit_interval_timer`

## Requirements
- R1: The interrupt rises exactly (reload + 1) * DIV clock edges after the edge that wrote the reload value, where DIV = CLK_HZ / BASE_HZ. While left alone, it keeps expiring every (reload + 1) * DIV edges after that.
- R2: Once raised, `irq` stays high across any number of further period expiries until an acknowledge arrives.
- R3: A read (`bus_sel` = 1 and `rd_stb` = 1) drives `irq` low after that edge. In the same cycle, `rd_data` shows the reload value in bits [8:0] with all upper bits zero. When no read is selected, `rd_data` is zero.
- R4: A write (`bus_sel` = 1 and `wr_stb` = 1) drives `irq` low after that edge and starts a new full period with the newly written value.
- R5: Reset sets the reload value to 0 and holds `irq` low. With no write after reset, the first rise comes DIV edges after reset is released.
- R6: Only `wr_data[8:0]` is stored. Bits above bit 8 are ignored, both in the value read back and in the period.
- R7: When an acknowledge and a period expiry fall on the same edge, the acknowledge wins and `irq` stays low. The next period starts at that edge.
- R8: Strobes with `bus_sel` = 0 change neither the reload value, nor `irq`, nor the timing.
- R9: A read acknowledge does not restart the period. The next expiry stays on the grid set by the last write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously upstream |
| bus_sel | input | 1 | Address select for the timer location |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wr_data | input | DATA_W | Write data; the low 9 bits are the reload value |
| rd_data | output | DATA_W | Reload value, zero-extended, while a selected read is active |
| irq | output | 1 | Level interrupt, high from period expiry until acknowledged |

## Verification
The hardest case to reach is an acknowledge that lands on the very edge where a period expires. The bench gets there by counting edges from a known write, so that the read strobe is active exactly on the (reload + 1) * DIV-th edge. A second hard case is showing that a read acknowledge leaves the period grid untouched. For this, every swept reload value is acknowledged one edge after the interrupt rises, and the bench then checks that the next rise still arrives on the original grid. The bench uses a small clock-frequency parameter, so that DIV is 8 and every value of the 9-bit reload range reaches expiry within a few thousand cycles.

// File: rtl/pit_pkg.sv
package pit_pkg;
  // Base tick rate the prescaler targets (1 ms ticks)
  localparam int unsigned BASE_HZ = 1000;

  // Decoded access controls shared by the submodules
  typedef struct packed {
    logic ack;      // clear the interrupt
    logic restart;  // reload write: restart prescaler and period
  } pit_ctl_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] cnt_q, cnt_d;

      always_comb begin
        if (clr)                cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = (cnt_q == LAST) && !clr;
    end
  endgenerate
endmodule

// File: rtl/pit_period_ctr.sv
module pit_period_ctr #(
  parameter int unsigned RW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic [RW-1:0] reload,
  output logic          expire,
  output logic [RW-1:0] cnt
);
  logic [RW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == reload);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (tick)   cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = tick && at_end && !restart;
  assign cnt    = cnt_q;
endmodule

// File: rtl/pit_irq_flag.sv
module pit_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  logic irq_q, irq_d;

  // clear has priority over a coincident set
  always_comb begin
    irq_d = irq_q;
    if (clr)      irq_d = 1'b0;
    else if (set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/pit_interval_timer.sv
module pit_interval_timer
  import pit_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned RELOAD_W = 9,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int unsigned DIV = CLK_HZ / BASE_HZ;

  pit_ctl_t      ctl;
  logic [RELOAD_W-1:0] reload_q, reload_d;
  logic                base_tick;
  logic                period_end;
  logic [RELOAD_W-1:0] period_cnt;

  // access decode
  always_comb begin
    ctl.restart = bus_sel && wr_stb;
    ctl.ack     = bus_sel && (wr_stb || rd_stb);
  end

  // reload register with explicit write enable
  always_comb begin
    reload_d = reload_q;
    if (ctl.restart) reload_d = wr_data[RELOAD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_q <= '0;
    else        reload_q <= reload_d;
  end

  pit_prescaler #(.DIV(DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctl.restart),
    .tick  (base_tick)
  );

  pit_period_ctr #(.RW(RELOAD_W)) u_per (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (base_tick),
    .restart (ctl.restart),
    .reload  (reload_q),
    .expire  (period_end),
    .cnt     (period_cnt)
  );

  pit_irq_flag u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (period_end),
    .clr   (ctl.ack),
    .irq   (irq)
  );

  assign rd_data = (bus_sel && rd_stb) ? DATA_W'(reload_q) : '0;
endmodule

// File: rtl/pit_interval_timer_chk.sv
module pit_interval_timer_chk #(
  parameter int unsigned RW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic          irq,
  input logic          base_tick,
  input logic [RW-1:0] period_cnt,
  input logic [RW-1:0] reload_q
);
  logic acc_ack;
  logic acc_wr;
  assign acc_ack = bus_sel && (wr_stb || rd_stb);
  assign acc_wr  = bus_sel && wr_stb;

  // R2
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !acc_ack) |=> irq);

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |=> !irq);

  // R1
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(base_tick));

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> (period_cnt <= reload_q));

  // R8
  reload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(reload_q));
endmodule

bind pit_interval_timer pit_interval_timer_chk #(.RW(RELOAD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .wr_stb     (wr_stb),
  .rd_stb     (rd_stb),
  .irq        (irq),
  .base_tick  (base_tick),
  .period_cnt (period_cnt),
  .reload_q   (reload_q)
);

// File: tb/pit_interval_timer_tb.sv
`timescale 1ns/1ps
module pit_interval_timer_tb;
  localparam int unsigned CLK_HZ = 8000;   // DIV = 8
  localparam int unsigned DIV    = CLK_HZ / 1000;
  localparam int unsigned DW     = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, wr_stb, rd_stb;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pit_interval_timer #(.CLK_HZ(CLK_HZ), .RELOAD_W(9), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Caller is at the negedge after edge E0. Expects irq low after
  // edges 1..n-1 and high after edge n.
  task automatic expect_rise(input int n, input string req);
    int first_bad = -1;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      if (irq !== 1'b0 && first_bad < 0) first_bad = i;
    end
    chk(first_bad < 0, req, first_bad, -1);
    @(negedge clk);
    chk(irq === 1'b1, req, int'(irq), 1);
  endtask

  task automatic idle(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq !== 1'b0) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic do_write(input logic [DW-1:0] v, input logic sel);
    bus_sel = sel; wr_stb = 1'b1; wr_data = v;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; wr_stb = 1'b0; wr_data = '0;
  endtask

  task automatic do_read(output logic [DW-1:0] v);
    bus_sel = 1'b1; rd_stb = 1'b1;
    #1 v = rd_data;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; rd_stb = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] rv;
    int vals [3] = '{100, 255, 511};
    bus_sel = 0; wr_stb = 0; rd_stb = 0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R5: reset state
    chk(irq === 1'b0, "R5 irq in reset", int'(irq), 0);
    chk(rd_data === '0, "R3 rd_data idle", int'(rd_data), 0);
    rst_n = 1'b1;
    expect_rise(DIV, "R5 first rise after reset");
    do_read(rv);
    chk(rv === 16'd0, "R5 reload after reset", int'(rv), 0);
    chk(irq === 1'b0, "R3 read ack", int'(irq), 0);

    // R1/R3/R9 sweep over reload values
    for (int r = 0; r < 19; r++) begin
      int rl = (r < 16) ? r : vals[r-16];
      int p  = (rl + 1) * DIV;
      do_write(DW'(rl), 1'b1);
      chk(irq === 1'b0, "R4 write ack", int'(irq), 0);
      expect_rise(p, "R1 period");
      do_read(rv);
      chk(rv === DW'(rl), "R3 read value", int'(rv), rl);
      chk(irq === 1'b0, "R3 read ack", int'(irq), 0);
      expect_rise(p - 1, "R9 grid after read");
    end

    // R2: irq held across several expiries
    do_write(16'd2, 1'b1);
    expect_rise(3 * DIV, "R2 rise");
    repeat (3 * 3 * DIV) @(negedge clk);
    chk(irq === 1'b1, "R2 held", int'(irq), 1);
    do_read(rv);
    chk(irq === 1'b0, "R2 cleared by read", int'(irq), 0);

    // R6: upper write bits ignored (0xFE05 -> 5)
    do_write(16'hFE05, 1'b1);
    expect_rise(6 * DIV, "R6 period uses low bits");
    do_read(rv);
    chk(rv === 16'd5, "R6 read value", int'(rv), 5);

    // R7: read ack on the expiry edge
    do_write(16'd1, 1'b1);
    idle(2 * DIV - 1, "R7 before expiry");
    do_read(rv);  // ack coincides with edge 2*DIV
    chk(irq === 1'b0, "R7 ack wins", int'(irq), 0);
    expect_rise(2 * DIV, "R7 next period");

    // R7/R4: write on the expiry edge restarts
    do_write(16'd1, 1'b1);
    idle(2 * DIV - 1, "R7 before expiry w");
    do_write(16'd3, 1'b1);
    chk(irq === 1'b0, "R7 write ack wins", int'(irq), 0);
    expect_rise(4 * DIV, "R4 restart with new value");

    // R4: write mid-period restarts from zero
    do_write(16'd3, 1'b1);
    idle(10, "R4 mid");
    do_write(16'd2, 1'b1);
    expect_rise(3 * DIV, "R4 restart mid-period");

    // R8: unselected strobes have no effect
    do_write(16'd3, 1'b1);
    idle(4, "R8 pre");
    do_write(16'd9, 1'b0);
    bus_sel = 1'b0; rd_stb = 1'b1;
    #1 chk(rd_data === '0, "R8 unselected read data", int'(rd_data), 0);
    @(negedge clk); rd_stb = 1'b0;
    expect_rise(4 * DIV - 6, "R8 timing unchanged");
    bus_sel = 1'b0; rd_stb = 1'b1;
    repeat (2) @(negedge clk);
    rd_stb = 1'b0;
    chk(irq === 1'b1, "R8 unselected read no ack", int'(irq), 1);
    do_read(rv);
    chk(rv === 16'd3, "R8 reload unchanged", int'(rv), 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule